// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide asynchronous static RAM. It has an active-low select, an active-low output enable, an active-low write enable and one active-low enable per byte lane. It serves as the memory side of a controller under test, either in simulation or on a programmable-logic board. On every rising clock edge it samples the control inputs and sorts them into one of five modes: deselected, read, write, outputs disabled, or no lane enabled. It then performs a byte-masked write, or returns the stored data on the enabled lanes.

The bidirectional data pins are split into a write-data input, a read-data output and a per-lane drive flag. The drive flag marks the lanes on which a real part would be driving the bus. A testbench can compare it against its own controller's drive enable to catch contention. Read data and drive flags are registered together, so both appear one clock after the inputs are sampled. A registered standby flag follows deselection. The address width is a parameter: 16 bits gives the full 64K-word array, and the default is smaller for quick elaboration.

Top module: `bytelane_sram`

## Requirements
- R1: While reset is asserted, and right after it, drive flags are 0, read data is all zeros and standby is 1.
- R2: When select is high at a sampling edge, the following cycle shows drive flags 0 and standby 1, and nothing is written, whatever the other inputs are.
- R3: With select low, write enable high and output enable low, each lane whose enable is low shows the stored byte and raises its drive flag in the next cycle. A lane whose enable is high has its flag low. Lane 0 is data bits 7:0 with enable bit 0, and lane 1 is bits 15:8 with enable bit 1.
- R4: With select low and write enable low, every lane whose enable is low stores its write-data byte at the sampled address, even when output enable is low. The drive flags in the next cycle are 0.
- R5: With select low and both output enable and write enable high, the next cycle shows drive flags 0 and standby 0.
- R6: With select low and both lane enables high, no byte is written and the drive flags in the next cycle are 0, in any mode.
- R7: Outputs change only at the clock edge that samples the inputs (one cycle of latency). A lane whose drive flag is low presents all zeros on its read data.
- R8: A write to one lane leaves the other lane's byte at that address, and the bytes at every other address, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| sel_n | input | 1 | Active-low chip select |
| oen_n | input | 1 | Active-low output enable |
| wen_n | input | 1 | Active-low write enable |
| lane_en_n | input | LANES (2) | Active-low byte-lane enables, bit 0 = low byte |
| addr | input | ADDR_W (10) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Registered read data, zero on undriven lanes |
| lane_drive | output | LANES (2) | Registered per-lane drive flag |
| standby | output | 1 | Registered deselect indicator |

## Verification
The bench builds the block with a 6-bit address and the default two 8-bit lanes. With only 64 words, both the top and the bottom address are written and read back in a few cycles. Single-lane writes and reads can be checked against a neighbouring byte whose value is known. The narrow array also makes it cheap to confirm that deselected, lane-less and output-disabled cycles leave stored data intact.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_OUTOFF  = 3'd3,
    MODE_NOLANE  = 3'd4
  } sram_mode_e;

  // Priority: deselect, then no lane, then write (beats output enable), then read.
  function automatic sram_mode_e decode_mode(input logic sel_n, input logic oen_n,
                                             input logic wen_n, input logic any_lane);
    sram_mode_e m;
    if (sel_n)          m = MODE_STANDBY;
    else if (!any_lane) m = MODE_NOLANE;
    else if (!wen_n)    m = MODE_WRITE;
    else if (!oen_n)    m = MODE_READ;
    else                m = MODE_OUTOFF;
    return m;
  endfunction

  function automatic logic mode_writes(input sram_mode_e m);
    return m == MODE_WRITE;
  endfunction

  function automatic logic mode_reads(input sram_mode_e m);
    return m == MODE_READ;
  endfunction

endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             oen_n,
  input  logic             wen_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);

  logic any_lane;
  logic do_write;
  logic do_read;

  assign any_lane = ~&lane_en_n;
  assign mode     = decode_mode(sel_n, oen_n, wen_n, any_lane);
  assign do_write = mode_writes(mode);
  assign do_read  = mode_reads(mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_lane[g] = do_write & ~lane_en_n[g];
    assign rd_lane[g] = do_read  & ~lane_en_n[g];
  end

  // R4: a lane is never both written and read in one sampling cycle
  a_r4_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane & rd_lane) == '0);

  // R6: no write strobe when every lane enable is high
  a_r6_nolane_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_en_n) |-> (wr_lane == '0));

  // R2: deselect suppresses every strobe
  a_r2_sel_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (wr_lane == '0 && rd_lane == '0));

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              drive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive <= 1'b0;
      rdata <= '0;
    end else begin
      drive <= rd_en;
      rdata <= rd_en ? mem[addr] : '0;
    end
  end

  // R7: an undriven lane presents zeros
  a_r7_quiet_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (rdata == '0));

  // R8: without a strobe, the addressed byte keeps its value
  a_r8_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem[$past(addr)] == $past(mem[addr])));

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    oen_n,
  input  logic                    wen_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drive,
  output logic                    standby
);

  sram_mode_e       mode_w;
  logic [LANES-1:0] wr_lane_w;
  logic [LANES-1:0] rd_lane_w;

  sram_decode #(.LANES(LANES)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .oen_n     (oen_n),
    .wen_n     (wen_n),
    .lane_en_n (lane_en_n),
    .mode      (mode_w),
    .wr_lane   (wr_lane_w),
    .rd_lane   (rd_lane_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr_en (wr_lane_w[g]),
      .rd_en (rd_lane_w[g]),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (rdata[g*LANE_W +: LANE_W]),
      .drive (lane_drive[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) standby <= 1'b1;
    else        standby <= (mode_w == MODE_STANDBY);
  end

  // R2: deselect gives quiet lanes and standby
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (lane_drive == '0 && standby));

  // R4: lanes are not driven after a write cycle
  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wen_n) |=> (lane_drive == '0));

  // R3: read drives exactly the enabled lanes
  a_r3_drive_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wen_n && !oen_n) |=> (lane_drive == ~$past(lane_en_n)));

  // R5: outputs disabled while selected
  a_r5_outoff_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wen_n && oen_n) |=> (lane_drive == '0 && !standby));

endmodule

// File: tb/bytelane_sram_bench.sv
`timescale 1ns/1ps
module bytelane_sram_bench;

  localparam int AW = 6;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, oen_n = 1'b1, wen_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_drive;
  logic        standby;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) u_bytelane_sram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oen_n(oen_n), .wen_n(wen_n),
    .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_drive(lane_drive), .standby(standby)
  );

  // {sel_n, oen_n, wen_n, lane_en_n[1:0], addr[5:0], wdata, exp_drive, exp_rdata, exp_standby}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,2'b00,6'd5, 16'hA1B2,2'b00,16'h0000,1'b0}, // R4 full write
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'hA1B2,1'b0}, // R3 read both
    {1'b0,1'b0,1'b0,2'b10,6'd5, 16'hFFCC,2'b00,16'h0000,1'b0}, // R4 low lane, oe low
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'hA1CC,1'b0}, // R8 high byte kept
    {1'b0,1'b1,1'b0,2'b01,6'd5, 16'h3344,2'b00,16'h0000,1'b0}, // R4 high lane
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'h33CC,1'b0}, // R8 low byte kept
    {1'b0,1'b0,1'b1,2'b10,6'd5, 16'h0000,2'b01,16'h00CC,1'b0}, // R3 R7 low only
    {1'b0,1'b0,1'b1,2'b01,6'd5, 16'h0000,2'b10,16'h3300,1'b0}, // R3 R7 high only
    {1'b1,1'b0,1'b0,2'b00,6'd5, 16'h0000,2'b00,16'h0000,1'b1}, // R2 deselect w/ write
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'h33CC,1'b0}, // R2 nothing written
    {1'b0,1'b0,1'b0,2'b11,6'd5, 16'h1111,2'b00,16'h0000,1'b0}, // R6 no lanes
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'h33CC,1'b0}, // R6 nothing written
    {1'b0,1'b1,1'b1,2'b00,6'd5, 16'h0000,2'b00,16'h0000,1'b0}, // R5 outputs off
    {1'b0,1'b1,1'b0,2'b00,6'd63,16'hBEEF,2'b00,16'h0000,1'b0}, // R4 top address
    {1'b0,1'b1,1'b0,2'b00,6'd0, 16'h1234,2'b00,16'h0000,1'b0}, // R4 bottom address
    {1'b0,1'b0,1'b1,2'b00,6'd63,16'h0000,2'b11,16'hBEEF,1'b0}, // R3 top readback
    {1'b0,1'b0,1'b1,2'b00,6'd0, 16'h0000,2'b11,16'h1234,1'b0}, // R3 bottom readback
    {1'b0,1'b0,1'b1,2'b00,6'd5, 16'h0000,2'b11,16'h33CC,1'b0}  // R8 other address intact
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [45:0] v);
    sel_n = v[45]; oen_n = v[44]; wen_n = v[43];
    lane_en_n = v[42:41]; addr = v[40:35]; wdata = v[34:19];
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 drive", 32'(lane_drive), 32'h0);
    check("R1 rdata", 32'(rdata), 32'h0);
    check("R1 standby", 32'(standby), 32'h1);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("vec%0d drive", i), 32'(lane_drive), 32'(VEC[i][18:17]));
      check($sformatf("vec%0d rdata", i), 32'(rdata), 32'(VEC[i][16:1]));
      check($sformatf("vec%0d standby", i), 32'(standby), 32'(VEC[i][0]));
    end

    // R7: latency of one cycle; outputs stay until the sampling edge
    sel_n = 1'b1; @(negedge clk);
    sel_n = 1'b0; oen_n = 1'b0; wen_n = 1'b1; lane_en_n = 2'b00; addr = 6'd63;
    #1;
    check("R7 before edge drive", 32'(lane_drive), 32'h0);
    check("R7 before edge standby", 32'(standby), 32'h1);
    @(negedge clk);
    check("R7 after edge drive", 32'(lane_drive), 32'h3);
    check("R7 after edge rdata", 32'(rdata), 32'hBEEF);

    // R1: reset in the middle of a read
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 midrun drive", 32'(lane_drive), 32'h0);
    check("R1 midrun rdata", 32'(rdata), 32'h0);
    check("R1 midrun standby", 32'(standby), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 read after reset", 32'(rdata), 32'hBEEF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule